// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block is the programmer-visible register file of a small accumulator machine. It holds two 8-bit accumulators, A and B, which together read as the 16-bit pair D with A in the upper byte. It also holds two 16-bit index registers, X and Y. Every clock cycle it can carry out one of these operations between them:

- load an immediate value,
- a generic copy,
- a dedicated byte copy between the two accumulators,
- an exchange,
- a sign-extension.

Alongside the registers it keeps the negative (N), zero (Z) and overflow (V) condition flags.

When source and destination widths differ, the operation decides how the gap is bridged. A copy sign-extends a byte that widens, an exchange zero-extends it, and any move into a byte keeps only bits 7:0. The generic copy and the sign-extension leave the flags alone. Loads and the dedicated accumulator copies rewrite N and Z and clear V.

Instruction decode, memory, the arithmetic unit and the carry flag belong to other blocks. The unit only sees an operation code, two register selects and a load value. All results come from registers and are visible after the clock edge that accepts the operation.

Top module: `rxu_top`

## Requirements
- R1: While `rst` is high at a clock edge, A, B, X, Y and the N, Z and V flags all become 0.
- R2: Operation code 1 (load) writes `ld_val` into the register chosen by `dst`. An 8-bit destination takes bits 7:0. N is set to the top bit of the destination width, Z is set when every destination bit is 0, and V is cleared.
- R3: Output `d` always equals {A, B}. Writing D (select 2) puts bits 15:8 into A and bits 7:0 into B.
- R4: Operation code 2 (generic copy) copies `src` to `dst`. An 8-bit source into a 16-bit destination is sign-extended, and a 16-bit source into an 8-bit destination keeps bits 7:0. The N, Z and V flags do not change.
- R5: Operation code 3 copies A into B and code 4 copies B into A. Both set N and Z from the copied byte and clear V.
- R6: Operation code 5 (exchange) swaps `src` and `dst` in one cycle, both reading their old values. If an 8-bit accumulator meets a 16-bit register, the accumulator receives the low byte and the 16-bit register receives 0x00 followed by the old accumulator byte. Flags do not change.
- R7: Operation code 6 (sign-extend) writes the sign-extended 8-bit `src` accumulator into a 16-bit `dst` (D, X or Y) and leaves the flags unchanged. Any other width pairing has no effect.
- R8: A copy or exchange with `src` equal to `dst` leaves every register unchanged. An exchange between D and A or B has no effect.
- R9: Operation codes 0 and 7, and any operation that uses a select value of 5, 6 or 7, change no register and no flag. Valid selects are A=0, B=1, D=2, X=3 and Y=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code (0 none, 1 load, 2 copy, 3 A to B, 4 B to A, 5 exchange, 6 sign-extend, 7 none) |
| src | input | 3 | Source register select |
| dst | input | 3 | Destination register select |
| ld_val | input | 16 | Immediate value for a load |
| a | output | 8 | Accumulator A |
| b | output | 8 | Accumulator B |
| d | output | 16 | Pair {A, B} |
| x | output | 16 | Index register X |
| y | output | 16 | Index register Y |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Every operation presented before a rising edge shows its full result on the registers and flags right after that edge. There is one cycle of latency and no later effect. The bench applies each operation at a falling edge and returns the operation code to 0 at the next falling edge. It then compares the outputs at that same falling edge, half a period after the update, so a value is never read while it is changing. Checks of unchanged state take a snapshot of the outputs before the stimulus and compare against it one cycle later.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_MOVE = 3'd2,
    OP_A2B  = 3'd3,
    OP_B2A  = 3'd4,
    OP_SWAP = 3'd5,
    OP_SEXT = 3'd6,
    OP_RSVD = 3'd7
  } rxu_op_e;

  typedef enum logic [2:0] {
    SEL_A  = 3'd0,
    SEL_B  = 3'd1,
    SEL_D  = 3'd2,
    SEL_X  = 3'd3,
    SEL_Y  = 3'd4,
    SEL_U5 = 3'd5,
    SEL_U6 = 3'd6,
    SEL_U7 = 3'd7
  } rxu_sel_e;

  localparam int unsigned NUM_WR = 2;
endpackage

// File: rtl/rxu_rdport.sv
module rxu_rdport #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic [2:0]        sel,
  input  logic [BYTE_W-1:0] a_q,
  input  logic [BYTE_W-1:0] b_q,
  input  logic [WORD_W-1:0] x_q,
  input  logic [WORD_W-1:0] y_q,
  output logic [WORD_W-1:0] val,
  output logic              is_byte,
  output logic              ok
);
  import rxu_pkg::*;

  always_comb begin
    val     = '0;
    is_byte = 1'b0;
    ok      = 1'b1;
    case (rxu_sel_e'(sel))
      SEL_A: begin val = {{BYTE_W{1'b0}}, a_q}; is_byte = 1'b1; end
      SEL_B: begin val = {{BYTE_W{1'b0}}, b_q}; is_byte = 1'b1; end
      SEL_D: val = {a_q, b_q};
      SEL_X: val = x_q;
      SEL_Y: val = y_q;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxu_engine.sv
module rxu_engine #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned NWR = rxu_pkg::NUM_WR
) (
  input  logic [2:0]                  op,
  input  logic [2:0]                  src,
  input  logic [2:0]                  dst,
  input  logic [WORD_W-1:0]           ld_val,
  input  logic [WORD_W-1:0]           s_val,
  input  logic                        s_byte,
  input  logic                        s_ok,
  input  logic [WORD_W-1:0]           d_val,
  input  logic                        d_byte,
  input  logic                        d_ok,
  input  logic [BYTE_W-1:0]           a_q,
  input  logic [BYTE_W-1:0]           b_q,
  output logic [NWR-1:0]              wr_en,
  output logic [NWR-1:0][2:0]         wr_sel,
  output logic [NWR-1:0][WORD_W-1:0]  wr_data,
  output logic                        flg_upd,
  output logic                        flg_n,
  output logic                        flg_z
);
  import rxu_pkg::*;

  function automatic logic [WORD_W-1:0] fit(input logic [WORD_W-1:0] v,
                                             input logic from_byte,
                                             input logic to_byte,
                                             input logic sext);
    logic [WORD_W-1:0] r;
    if (from_byte && !to_byte)
      r = sext ? {{BYTE_W{v[BYTE_W-1]}}, v[BYTE_W-1:0]}
               : {{BYTE_W{1'b0}}, v[BYTE_W-1:0]};
    else if (to_byte)
      r = {{BYTE_W{1'b0}}, v[BYTE_W-1:0]};
    else
      r = v;
    return r;
  endfunction

  logic same_sel;
  logic pair_overlap;

  always_comb begin
    same_sel     = (src == dst);
    pair_overlap = ((rxu_sel_e'(src) == SEL_D) && d_byte) ||
                   ((rxu_sel_e'(dst) == SEL_D) && s_byte);
  end

  always_comb begin
    wr_en   = '0;
    wr_sel  = '0;
    wr_data = '0;
    flg_upd = 1'b0;
    flg_n   = 1'b0;
    flg_z   = 1'b0;
    case (rxu_op_e'(op))
      OP_LOAD: if (d_ok) begin
        wr_en[0]   = 1'b1;
        wr_sel[0]  = dst;
        wr_data[0] = d_byte ? {{BYTE_W{1'b0}}, ld_val[BYTE_W-1:0]} : ld_val;
        flg_upd    = 1'b1;
        flg_n      = d_byte ? ld_val[BYTE_W-1] : ld_val[WORD_W-1];
        flg_z      = d_byte ? (ld_val[BYTE_W-1:0] == '0) : (ld_val == '0);
      end
      OP_MOVE: if (s_ok && d_ok && !same_sel) begin
        wr_en[0]   = 1'b1;
        wr_sel[0]  = dst;
        wr_data[0] = fit(s_val, s_byte, d_byte, 1'b1);
      end
      OP_A2B: begin
        wr_en[0]   = 1'b1;
        wr_sel[0]  = SEL_B;
        wr_data[0] = {{BYTE_W{1'b0}}, a_q};
        flg_upd    = 1'b1;
        flg_n      = a_q[BYTE_W-1];
        flg_z      = (a_q == '0);
      end
      OP_B2A: begin
        wr_en[0]   = 1'b1;
        wr_sel[0]  = SEL_A;
        wr_data[0] = {{BYTE_W{1'b0}}, b_q};
        flg_upd    = 1'b1;
        flg_n      = b_q[BYTE_W-1];
        flg_z      = (b_q == '0);
      end
      OP_SWAP: if (s_ok && d_ok && !same_sel && !pair_overlap) begin
        wr_en      = '1;
        wr_sel[0]  = dst;
        wr_data[0] = fit(s_val, s_byte, d_byte, 1'b0);
        wr_sel[1]  = src;
        wr_data[1] = fit(d_val, d_byte, s_byte, 1'b0);
      end
      OP_SEXT: if (s_ok && d_ok && s_byte && !d_byte) begin
        wr_en[0]   = 1'b1;
        wr_sel[0]  = dst;
        wr_data[0] = fit(s_val, 1'b1, 1'b0, 1'b1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxu_regfile.sv
module rxu_regfile #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned NWR = rxu_pkg::NUM_WR
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NWR-1:0]              wr_en,
  input  logic [NWR-1:0][2:0]         wr_sel,
  input  logic [NWR-1:0][WORD_W-1:0]  wr_data,
  output logic [BYTE_W-1:0]           a_q,
  output logic [BYTE_W-1:0]           b_q,
  output logic [WORD_W-1:0]           x_q,
  output logic [WORD_W-1:0]           y_q
);
  import rxu_pkg::*;

  logic [BYTE_W-1:0] a_n, b_n;
  logic [WORD_W-1:0] x_n, y_n;

  always_comb begin
    a_n = a_q;
    b_n = b_q;
    x_n = x_q;
    y_n = y_q;
    for (int k = 0; k < NWR; k++) begin
      if (wr_en[k]) begin
        case (rxu_sel_e'(wr_sel[k]))
          SEL_A: a_n = wr_data[k][BYTE_W-1:0];
          SEL_B: b_n = wr_data[k][BYTE_W-1:0];
          SEL_D: begin
            a_n = wr_data[k][WORD_W-1:BYTE_W];
            b_n = wr_data[k][BYTE_W-1:0];
          end
          SEL_X: x_n = wr_data[k];
          SEL_Y: y_n = wr_data[k];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      x_q <= '0;
      y_q <= '0;
    end else begin
      a_q <= a_n;
      b_q <= b_n;
      x_q <= x_n;
      y_q <= y_n;
    end
  end
endmodule

// File: rtl/rxu_top.sv
module rxu_top #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned NWR = rxu_pkg::NUM_WR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic [2:0]        src,
  input  logic [2:0]        dst,
  input  logic [WORD_W-1:0] ld_val,
  output logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] b,
  output logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] x,
  output logic [WORD_W-1:0] y,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v
);
  logic [BYTE_W-1:0] a_q, b_q;
  logic [WORD_W-1:0] x_q, y_q;

  logic [1:0][2:0]        rd_sel;
  logic [1:0][WORD_W-1:0] rd_val;
  logic [1:0]             rd_byte;
  logic [1:0]             rd_ok;

  logic [NWR-1:0]              wr_en;
  logic [NWR-1:0][2:0]         wr_sel;
  logic [NWR-1:0][WORD_W-1:0]  wr_data;
  logic                        flg_upd, flg_n, flg_z;
  logic                        n_q, z_q, v_q;

  assign rd_sel[0] = src;
  assign rd_sel[1] = dst;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    rxu_rdport #(.BYTE_W(BYTE_W)) u_rd (
      .sel     (rd_sel[p]),
      .a_q     (a_q),
      .b_q     (b_q),
      .x_q     (x_q),
      .y_q     (y_q),
      .val     (rd_val[p]),
      .is_byte (rd_byte[p]),
      .ok      (rd_ok[p])
    );
  end

  rxu_engine #(.BYTE_W(BYTE_W)) u_eng (
    .op      (op),
    .src     (src),
    .dst     (dst),
    .ld_val  (ld_val),
    .s_val   (rd_val[0]),
    .s_byte  (rd_byte[0]),
    .s_ok    (rd_ok[0]),
    .d_val   (rd_val[1]),
    .d_byte  (rd_byte[1]),
    .d_ok    (rd_ok[1]),
    .a_q     (a_q),
    .b_q     (b_q),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .flg_upd (flg_upd),
    .flg_n   (flg_n),
    .flg_z   (flg_z)
  );

  rxu_regfile #(.BYTE_W(BYTE_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .a_q     (a_q),
    .b_q     (b_q),
    .x_q     (x_q),
    .y_q     (y_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q <= 1'b0;
      z_q <= 1'b0;
      v_q <= 1'b0;
    end else if (flg_upd) begin
      n_q <= flg_n;
      z_q <= flg_z;
      v_q <= 1'b0;
    end
  end

  assign a      = a_q;
  assign b      = b_q;
  assign d      = {a_q, b_q};
  assign x      = x_q;
  assign y      = y_q;
  assign flag_n = n_q;
  assign flag_z = z_q;
  assign flag_v = v_q;
endmodule

// File: rtl/rxu_chk.sv
module rxu_chk #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op,
  input logic [2:0]        src,
  input logic [2:0]        dst,
  input logic [WORD_W-1:0] ld_val,
  input logic [BYTE_W-1:0] a,
  input logic [BYTE_W-1:0] b,
  input logic [WORD_W-1:0] x,
  input logic [WORD_W-1:0] y,
  input logic              flag_n,
  input logic              flag_z
);
  AST_LOAD_X_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1 && dst == 3'd3) |=> (x == $past(ld_val)) && (flag_z == ($past(ld_val) == '0))); // R2
  AST_MOVE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2) |=> $stable(flag_n) && $stable(flag_z)); // R4
  AST_A2B_COPY: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd3) |=> (b == $past(a)) && (flag_z == ($past(a) == '0))); // R5
  AST_SWAP_XY: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5 && ((src == 3'd3 && dst == 3'd4) || (src == 3'd4 && dst == 3'd3)))
    |=> (x == $past(y)) && (y == $past(x))); // R6
  AST_SEXT_AX: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd6 && src == 3'd0 && dst == 3'd3)
    |=> x == {{BYTE_W{$past(a[BYTE_W-1])}}, $past(a)}); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0 || op == 3'd7)
    |=> $stable(a) && $stable(b) && $stable(x) && $stable(y) && $stable(flag_n) && $stable(flag_z)); // R9
endmodule

bind rxu_top rxu_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op     (op),
  .src    (src),
  .dst    (dst),
  .ld_val (ld_val),
  .a      (a),
  .b      (b),
  .x      (x),
  .y      (y),
  .flag_n (flag_n),
  .flag_z (flag_z)
);

// File: tb/sim_rxu_top.sv
module sim_rxu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = 3'd0, src = 3'd0, dst = 3'd0;
  logic [15:0] ld_val = 16'h0;
  logic [7:0]  a, b;
  logic [15:0] d, x, y;
  logic        flag_n, flag_z, flag_v;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  localparam logic [2:0] NOP = 3'd0, LD = 3'd1, MV = 3'd2, A2B = 3'd3,
                         B2A = 3'd4, XG = 3'd5, SX = 3'd6, RSV = 3'd7;
  localparam logic [2:0] RA = 3'd0, RB = 3'd1, RD = 3'd2, RX = 3'd3, RY = 3'd4;

  always #10 clk = ~clk;

  rxu_top u0 (
    .clk(clk), .rst(rst), .op(op), .src(src), .dst(dst), .ld_val(ld_val),
    .a(a), .b(b), .d(d), .x(x), .y(y),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic n, input logic z, input logic v);
    chk(req, {13'h0, flag_n, flag_z, flag_v}, {13'h0, n, z, v});
  endtask

  task automatic run(input logic [2:0] o, input logic [2:0] s, input logic [2:0] t,
                     input logic [15:0] v);
    op = o; src = s; dst = t; ld_val = v;
    @(negedge clk);
    op = NOP;
  endtask

  task automatic t_reset();
    chk("R1 a", {8'h0, a}, 16'h0);
    chk("R1 b", {8'h0, b}, 16'h0);
    chk("R1 x", x, 16'h0);
    chk("R1 y", y, 16'h0);
    chk_flags("R1 flags", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_load();
    run(LD, RA, RA, 16'h1280);
    chk("R2 load A low byte", {8'h0, a}, 16'h0080);
    chk_flags("R2 load A flags", 1'b1, 1'b0, 1'b0);
    run(LD, RA, RX, 16'h0000);
    chk("R2 load X", x, 16'h0000);
    chk_flags("R2 load X zero flags", 1'b0, 1'b1, 1'b0);
    run(LD, RA, RD, 16'hBEEF);
    chk("R3 load D -> A", {8'h0, a}, 16'h00BE);
    chk("R3 load D -> B", {8'h0, b}, 16'h00EF);
    chk("R3 d pair", d, 16'hBEEF);
    chk_flags("R2 load D flags", 1'b1, 1'b0, 1'b0);
    run(LD, RA, RY, 16'h8001);
    chk("R2 load Y", y, 16'h8001);
  endtask

  task automatic t_move();
    run(MV, RA, RX, 16'h0);
    chk("R4 A->X sign-extend", x, 16'hFFBE);
    chk_flags("R4 flags held", 1'b1, 1'b0, 1'b0);
    run(MV, RY, RB, 16'h0);
    chk("R4 Y->B low byte", {8'h0, b}, 16'h0001);
    run(LD, RA, RB, 16'h007F);
    run(MV, RB, RY, 16'h0);
    chk("R4 B->Y positive", y, 16'h007F);
    chk_flags("R4 flags held after load", 1'b0, 1'b0, 1'b0);
    run(MV, RD, RX, 16'h0);
    chk("R4 D->X", x, 16'hBE7F);
  endtask

  task automatic t_accs();
    run(LD, RA, RA, 16'h0000);
    run(LD, RA, RB, 16'h0055);
    run(A2B, RA, RA, 16'h0);
    chk("R5 A->B value", {8'h0, b}, 16'h0000);
    chk_flags("R5 A->B flags", 1'b0, 1'b1, 1'b0);
    run(LD, RA, RB, 16'h0090);
    run(LD, RA, RX, 16'h0000);
    run(B2A, RA, RA, 16'h0);
    chk("R5 B->A value", {8'h0, a}, 16'h0090);
    chk_flags("R5 B->A flags", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_swap();
    run(LD, RA, RA, 16'h0012);
    run(LD, RA, RX, 16'hABCD);
    run(XG, RA, RX, 16'h0);
    chk("R6 A<->X acc", {8'h0, a}, 16'h00CD);
    chk("R6 A<->X wide", x, 16'h0012);
    chk_flags("R6 flags held", 1'b1, 1'b0, 1'b0);
    run(LD, RA, RX, 16'h1111);
    run(LD, RA, RY, 16'h2222);
    run(XG, RX, RY, 16'h0);
    chk("R6 X<->Y x", x, 16'h2222);
    chk("R6 X<->Y y", y, 16'h1111);
    run(LD, RA, RB, 16'h0034);
    run(XG, RA, RB, 16'h0);
    chk("R6 A<->B", d, 16'h34CD);
  endtask

  task automatic t_sext();
    run(LD, RA, RA, 16'h0080);
    run(LD, RA, RB, 16'h007F);
    run(SX, RA, RY, 16'h0);
    chk("R7 sext A->Y", y, 16'hFF80);
    chk_flags("R7 flags held", 1'b0, 1'b0, 1'b0);
    run(SX, RB, RX, 16'h0);
    chk("R7 sext B->X", x, 16'h007F);
    run(SX, RX, RA, 16'h0);
    chk("R7 wrong widths ignored", d, 16'h807F);
  endtask

  task automatic t_same();
    logic [15:0] sx, sy, sd;
    run(LD, RA, RX, 16'h4321);
    sx = x; sy = y; sd = d;
    run(MV, RX, RX, 16'h0);
    chk("R8 copy X->X", x, sx);
    run(XG, RY, RY, 16'h0);
    chk("R8 exchange Y,Y", y, sy);
    run(XG, RA, RD, 16'h0);
    chk("R8 exchange A,D ignored", d, sd);
    run(XG, RD, RB, 16'h0);
    chk("R8 exchange D,B ignored", d, sd);
  endtask

  task automatic t_idle();
    logic [15:0] sx, sy, sd;
    logic [2:0]  sf;
    sx = x; sy = y; sd = d; sf = {flag_n, flag_z, flag_v};
    run(NOP, RA, RX, 16'hFFFF);
    run(RSV, RA, RX, 16'hFFFF);
    run(LD, RA, 3'd5, 16'h0000);
    run(MV, 3'd6, RX, 16'h0);
    run(XG, RX, 3'd7, 16'h0);
    chk("R9 x held", x, sx);
    chk("R9 y held", y, sy);
    chk("R9 d held", d, sd);
    chk("R9 flags held", {13'h0, flag_n, flag_z, flag_v}, {13'h0, sf});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_move();
    t_accs();
    t_swap();
    t_sext();
    t_same();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule